// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller

This block keeps one cache line coherent with the other caches on a shared snooping bus. It follows a write-invalidate, write-back scheme with three stable line states: invalid, shared (clean and read only), and exclusive (dirty, readable and writable). Processor requests and snooped bus transactions arrive at the same time. The controller decides each cycle which of them it acts on.

The processor holds a request (read or write, with a block address) until `cpu_ready` is high in the cycle the request is presented. A hit is served from the stored line with no bus traffic. A miss, a write to a clean line, or a dirty line that must yield to a snoop parks the controller in a pending state. The pending state keeps a bus request up with a fixed command until the arbiter grants it for one cycle. A dirty line that has to make room for a new block first goes through a write-back pending state, then through the read-miss or write-miss pending state. The line's data is loaded from `bus_fill` on the cycle a read-miss or write-miss is granted.

Top module: `snp_line_ctrl`

## Requirements
- R1: After reset, `line_state` is 0 (invalid), `cpu_ready` is 1 and `bus_req` is 0.
- R2: From invalid, a processor read raises bus command 1 (read miss) for the request address, and the line becomes shared (`line_state` 1) holding `bus_fill` on the grant. A processor write raises command 2 (write miss), and the line becomes exclusive (`line_state` 2) on the grant. The held write then lands on the next accepted cycle.
- R3: In shared, a read to the stored address returns the stored data on `cpu_rdata`. It raises no bus request and leaves the state unchanged.
- R4: In shared, a write to the stored address raises command 2 and ends in exclusive, with the written data on `cpu_rdata`.
- R5: In shared, a snooped write miss (`snoop_wr` 1) to the stored address moves the line to invalid in the next cycle with no bus request. A snooped read miss (`snoop_wr` 0) to it changes nothing.
- R6: In exclusive, reads and writes to the stored address are served with no bus request. A write replaces the stored data, and the state stays 2.
- R7: In exclusive, a read or write to another address first raises command 3 (write-back) carrying the stored address and data. After that is granted, it raises command 1 or command 2 for the new address.
- R8: In exclusive, a snooped read miss to the stored address raises command 3 with the stored address and data, and the line becomes shared on the grant. The data is kept.
- R9: In exclusive, a snooped write miss to the stored address raises command 3 with the stored address and data, and the line becomes invalid on the grant.
- R10: While a bus action is pending, `line_state` reads 3, and `bus_req`, `bus_cmd` and `bus_addr` stay constant until `bus_gnt` is seen.
- R11: `cpu_ready` is low in every pending cycle and in any cycle where a snoop hits the valid stored address. Such a snoop is acted on before the processor request.
- R12: A snoop whose address differs from the stored address, or any snoop while the line is invalid, leaves the state, the data and the bus outputs unchanged.
- R13: In shared, a read to another address raises command 1 directly, without a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor block address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_ready | output | 1 | Request is accepted this cycle when high |
| cpu_rdata | output | DATA_W | Stored line data |
| snoop_valid | input | 1 | Snooped bus transaction present |
| snoop_wr | input | 1 | 1 = snooped write miss, 0 = snooped read miss |
| snoop_addr | input | ADDR_W | Snooped block address |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | One-cycle grant from the arbiter |
| bus_cmd | output | 2 | 0 idle, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of the bus action |
| bus_wdata | output | DATA_W | Write-back data, zero otherwise |
| bus_fill | input | DATA_W | Block data, sampled on a granted read or write miss |
| line_state | output | 2 | 0 invalid, 1 shared, 2 exclusive, 3 pending |

## Verification
The assertions assume that `bus_gnt` arrives only while `bus_req` is high. They also assume that the processor keeps `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until it sees `cpu_ready`. The directed tasks drive every input half a cycle away from the rising edge. Each task pulses the grant only after checking that the expected command is pending, and holds each processor request unchanged through its pending states. Snoops that coincide with a processor request are issued only in a stable state, so the collision case matches the priority the assertions expect.

// File: rtl/snp_pkg.sv
package snp_pkg;

   typedef enum logic [3:0] {
      ST_INV     = 4'd0,
      ST_SHR     = 4'd1,
      ST_EXC     = 4'd2,
      ST_PRD     = 4'd3,
      ST_PWM     = 4'd4,
      ST_PWB_RD  = 4'd5,
      ST_PWB_WM  = 4'd6,
      ST_PWB_SHR = 4'd7,
      ST_PWB_INV = 4'd8
   } line_st_e;

   typedef enum logic [1:0] {
      CMD_IDLE   = 2'd0,
      CMD_RDMISS = 2'd1,
      CMD_WRMISS = 2'd2,
      CMD_WBACK  = 2'd3
   } bus_cmd_e;

   localparam logic [1:0] VIS_INV  = 2'd0;
   localparam logic [1:0] VIS_SHR  = 2'd1;
   localparam logic [1:0] VIS_EXC  = 2'd2;
   localparam logic [1:0] VIS_BUSY = 2'd3;

   function automatic logic st_stable(input line_st_e s);
      return (s == ST_INV) || (s == ST_SHR) || (s == ST_EXC);
   endfunction

   function automatic logic st_valid(input line_st_e s);
      return (s == ST_SHR) || (s == ST_EXC);
   endfunction

endpackage

// File: rtl/snp_tag_cmp.sv
module snp_tag_cmp #(
   parameter int WIDTH = 16,
   parameter int SLICE = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic             eq
);
   localparam int NSL  = (WIDTH + SLICE - 1) / SLICE;
   localparam int PADW = NSL * SLICE;

   logic [PADW-1:0] a_pad;
   logic [PADW-1:0] b_pad;
   logic [NSL-1:0]  sl_eq;

   generate
      if (PADW == WIDTH) begin : g_nopad
         assign a_pad = a;
         assign b_pad = b;
      end else begin : g_pad
         assign a_pad = {{(PADW-WIDTH){1'b0}}, a};
         assign b_pad = {{(PADW-WIDTH){1'b0}}, b};
      end
      for (genvar i = 0; i < NSL; i++) begin : g_slice
         assign sl_eq[i] = (a_pad[i*SLICE +: SLICE] == b_pad[i*SLICE +: SLICE]);
      end
   endgenerate

   assign eq = &sl_eq;
endmodule

// File: rtl/snp_line_store.sv
module snp_line_store #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tag_we,
   input  logic [ADDR_W-1:0] tag_in,
   input  logic              data_we,
   input  logic [DATA_W-1:0] data_in,
   output logic [ADDR_W-1:0] tag_q,
   output logic [DATA_W-1:0] data_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q <= '0;
      end else if (tag_we) begin
         tag_q <= tag_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (data_we) begin
         data_q <= data_in;
      end
   end
endmodule

// File: rtl/snp_bus_drive.sv
module snp_bus_drive
   import snp_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  line_st_e          st,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] tag,
   input  logic [DATA_W-1:0] data,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [1:0]        vis_state
);
   bus_cmd_e cmd;

   always_comb begin
      cmd       = CMD_IDLE;
      vis_state = VIS_BUSY;
      unique case (st)
         ST_INV:     vis_state = VIS_INV;
         ST_SHR:     vis_state = VIS_SHR;
         ST_EXC:     vis_state = VIS_EXC;
         ST_PRD:     cmd = CMD_RDMISS;
         ST_PWM:     cmd = CMD_WRMISS;
         ST_PWB_RD,
         ST_PWB_WM,
         ST_PWB_SHR,
         ST_PWB_INV: cmd = CMD_WBACK;
         default:    cmd = CMD_IDLE;
      endcase
   end

   assign bus_req   = (cmd != CMD_IDLE);
   assign bus_cmd   = cmd;
   assign bus_addr  = ((cmd == CMD_RDMISS) || (cmd == CMD_WRMISS)) ? req_addr : tag;
   assign bus_wdata = (cmd == CMD_WBACK) ? data : '0;
endmodule

// File: rtl/snp_line_ctrl.sv
module snp_line_ctrl
   import snp_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int CMP_SLICE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              snoop_valid,
   input  logic              snoop_wr,
   input  logic [ADDR_W-1:0] snoop_addr,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_fill,
   output logic [1:0]        line_state
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("snp_line_ctrl: ADDR_W and DATA_W must be at least 1");
      end
      if (CMP_SLICE < 1 || CMP_SLICE > ADDR_W) begin : g_bad_slice
         $error("snp_line_ctrl: CMP_SLICE must lie in 1..ADDR_W");
      end
   endgenerate

   line_st_e          state_q, state_n;
   logic [ADDR_W-1:0] req_addr_q;
   logic              req_addr_we;
   logic [ADDR_W-1:0] tag_q;
   logic [DATA_W-1:0] data_q;
   logic              tag_we, data_we, data_from_cpu;
   logic [DATA_W-1:0] data_in;
   logic              cpu_tag_eq, snp_tag_eq;
   logic              cpu_hit, snoop_hit, accept;

   snp_tag_cmp #(.WIDTH(ADDR_W), .SLICE(CMP_SLICE)) u_cpu_cmp (
      .a(cpu_addr), .b(tag_q), .eq(cpu_tag_eq)
   );

   snp_tag_cmp #(.WIDTH(ADDR_W), .SLICE(CMP_SLICE)) u_snp_cmp (
      .a(snoop_addr), .b(tag_q), .eq(snp_tag_eq)
   );

   assign cpu_hit   = st_valid(state_q) && cpu_tag_eq;
   assign snoop_hit = snoop_valid && st_valid(state_q) && snp_tag_eq;
   assign cpu_ready = st_stable(state_q) && !snoop_hit;
   assign accept    = cpu_req && cpu_ready;

   always_comb begin
      state_n       = state_q;
      tag_we        = 1'b0;
      data_we       = 1'b0;
      data_from_cpu = 1'b0;
      req_addr_we   = 1'b0;
      unique case (state_q)
         ST_INV: begin
            if (accept) begin
               req_addr_we = 1'b1;
               state_n     = cpu_we ? ST_PWM : ST_PRD;
            end
         end
         ST_SHR: begin
            if (snoop_hit) begin
               if (snoop_wr) state_n = ST_INV;
            end else if (accept) begin
               if (cpu_we) begin
                  req_addr_we = 1'b1;
                  state_n     = ST_PWM;
               end else if (!cpu_hit) begin
                  req_addr_we = 1'b1;
                  state_n     = ST_PRD;
               end
            end
         end
         ST_EXC: begin
            if (snoop_hit) begin
               state_n = snoop_wr ? ST_PWB_INV : ST_PWB_SHR;
            end else if (accept) begin
               if (cpu_hit) begin
                  if (cpu_we) begin
                     data_we       = 1'b1;
                     data_from_cpu = 1'b1;
                  end
               end else begin
                  req_addr_we = 1'b1;
                  state_n     = cpu_we ? ST_PWB_WM : ST_PWB_RD;
               end
            end
         end
         ST_PRD: begin
            if (bus_gnt) begin
               tag_we  = 1'b1;
               data_we = 1'b1;
               state_n = ST_SHR;
            end
         end
         ST_PWM: begin
            if (bus_gnt) begin
               tag_we  = 1'b1;
               data_we = 1'b1;
               state_n = ST_EXC;
            end
         end
         ST_PWB_RD:  if (bus_gnt) state_n = ST_PRD;
         ST_PWB_WM:  if (bus_gnt) state_n = ST_PWM;
         ST_PWB_SHR: if (bus_gnt) state_n = ST_SHR;
         ST_PWB_INV: if (bus_gnt) state_n = ST_INV;
         default:    state_n = ST_INV;
      endcase
   end

   assign data_in = data_from_cpu ? cpu_wdata : bus_fill;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_INV;
      end else begin
         state_q <= state_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_addr_q <= '0;
      end else if (req_addr_we) begin
         req_addr_q <= cpu_addr;
      end
   end

   snp_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .tag_we  (tag_we),
      .tag_in  (req_addr_q),
      .data_we (data_we),
      .data_in (data_in),
      .tag_q   (tag_q),
      .data_q  (data_q)
   );

   snp_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
      .st        (state_q),
      .req_addr  (req_addr_q),
      .tag       (tag_q),
      .data      (data_q),
      .bus_req   (bus_req),
      .bus_cmd   (bus_cmd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .vis_state (line_state)
   );

   assign cpu_rdata = data_q;
endmodule

// File: rtl/snp_line_chk.sv
module snp_line_chk
   import snp_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_ready,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              snoop_valid,
   input logic              snoop_wr,
   input logic [ADDR_W-1:0] snoop_addr,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic [1:0]        bus_cmd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        line_state,
   input logic [3:0]        st,
   input logic [ADDR_W-1:0] tag
);
   logic in_shr, in_exc;
   assign in_shr = (st == 4'(ST_SHR));
   assign in_exc = (st == 4'(ST_EXC));

   assert_reset_invalid_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (line_state == 2'd0) && !bus_req);

   assert_shr_snoop_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_shr && snoop_valid && snoop_wr && (snoop_addr == tag)
      |=> (line_state == 2'd0) && !bus_req);

   assert_exc_miss_wback_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_exc && cpu_req && cpu_ready && (cpu_addr != tag)
      |=> bus_req && (bus_cmd == 2'd3) && (bus_addr == $past(tag)));

   assert_exc_snoop_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_exc && snoop_valid && !snoop_wr && (snoop_addr == tag)
      |=> (bus_cmd == 2'd3) && (line_state == 2'd3));

   assert_exc_snoop_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_exc && snoop_valid && snoop_wr && (snoop_addr == tag)
      |=> (bus_cmd == 2'd3) && (line_state == 2'd3));

   assert_pending_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_gnt
      |=> bus_req && $stable(bus_cmd) && $stable(bus_addr) && (line_state == 2'd3));

   assert_stall_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> !cpu_ready);

   assert_snoop_miss_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_shr || in_exc) && snoop_valid && (snoop_addr != tag) && !cpu_req
      |=> (line_state == $past(line_state)) && !bus_req);
endmodule

bind snp_line_ctrl snp_line_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_req     (cpu_req),
   .cpu_ready   (cpu_ready),
   .cpu_addr    (cpu_addr),
   .snoop_valid (snoop_valid),
   .snoop_wr    (snoop_wr),
   .snoop_addr  (snoop_addr),
   .bus_req     (bus_req),
   .bus_gnt     (bus_gnt),
   .bus_cmd     (bus_cmd),
   .bus_addr    (bus_addr),
   .line_state  (line_state),
   .st          (state_q),
   .tag         (tag_q)
);

// File: tb/sim_snp_line_ctrl.sv
`timescale 1ns/1ps
module sim_snp_line_ctrl;
   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ready;
   logic [DW-1:0] cpu_rdata;
   logic          snoop_valid = 1'b0, snoop_wr = 1'b0;
   logic [AW-1:0] snoop_addr = '0;
   logic          bus_req;
   logic          bus_gnt = 1'b0;
   logic [1:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_fill = '0;
   logic [1:0]    line_state;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam logic [AW-1:0] A = 16'h1234, B = 16'h5678, C = 16'h9abc, D = 16'h0ff0;

   always #4 clk = ~clk;

   snp_line_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .snoop_valid(snoop_valid), .snoop_wr(snoop_wr), .snoop_addr(snoop_addr),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_fill(bus_fill), .line_state(line_state)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic grant(input logic [DW-1:0] fill);
      bus_gnt  = 1'b1;
      bus_fill = fill;
      tick();
      bus_gnt  = 1'b0;
   endtask

   task automatic cpu_set(input logic we, input logic [AW-1:0] ad, input logic [DW-1:0] wd);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = ad; cpu_wdata = wd;
   endtask

   task automatic t_reset();
      chk("R1 state", line_state, 2'd0);
      chk("R1 ready", cpu_ready, 1'b1);
      chk("R1 bus_req", bus_req, 1'b0);
   endtask

   task automatic t_read_from_inv();
      cpu_set(1'b0, A, '0);
      #1 chk("R11 ready in invalid", cpu_ready, 1'b1);
      tick();
      chk("R2 rd cmd", bus_cmd, 2'd1);
      chk("R2 rd addr", bus_addr, A);
      chk("R10 busy state", line_state, 2'd3);
      chk("R11 stall", cpu_ready, 1'b0);
      tick();
      chk("R10 req held", bus_req, 1'b1);
      chk("R10 cmd held", bus_cmd, 2'd1);
      grant(32'hD1D1_0001);
      chk("R2 shared", line_state, 2'd1);
      chk("R2 fill", cpu_rdata, 32'hD1D1_0001);
      cpu_req = 1'b0;
   endtask

   task automatic t_shared_hit();
      cpu_set(1'b0, A, '0);
      #1;
      chk("R3 ready", cpu_ready, 1'b1);
      chk("R3 data", cpu_rdata, 32'hD1D1_0001);
      tick();
      cpu_req = 1'b0;
      chk("R3 state", line_state, 2'd1);
      chk("R3 no bus", bus_req, 1'b0);
   endtask

   task automatic t_shared_snoop_rd();
      snoop_valid = 1'b1; snoop_wr = 1'b0; snoop_addr = A;
      tick();
      snoop_valid = 1'b0;
      chk("R5 snoop rd state", line_state, 2'd1);
      chk("R5 snoop rd bus", bus_req, 1'b0);
   endtask

   task automatic shared_to_exc(input logic [AW-1:0] ad, input logic [DW-1:0] fill,
                                input logic [DW-1:0] wd, input string tag);
      cpu_set(1'b1, ad, wd);
      tick();
      chk({tag, " wm cmd"}, bus_cmd, 2'd2);
      chk({tag, " wm addr"}, bus_addr, ad);
      grant(fill);
      chk({tag, " exclusive"}, line_state, 2'd2);
      tick();
      cpu_req = 1'b0;
      chk({tag, " wdata"}, cpu_rdata, wd);
      chk({tag, " no bus"}, bus_req, 1'b0);
   endtask

   task automatic t_exc_hits();
      cpu_set(1'b1, A, 32'h0000_0202);
      tick();
      cpu_req = 1'b0;
      chk("R6 write hit data", cpu_rdata, 32'h0000_0202);
      chk("R6 write hit bus", bus_req, 1'b0);
      chk("R6 state", line_state, 2'd2);
      cpu_set(1'b0, A, '0);
      #1 chk("R6 read ready", cpu_ready, 1'b1);
      tick();
      cpu_req = 1'b0;
      chk("R6 read hit bus", bus_req, 1'b0);
      chk("R6 read state", line_state, 2'd2);
   endtask

   task automatic t_snoop_mismatch();
      snoop_valid = 1'b1; snoop_wr = 1'b1; snoop_addr = B;
      tick();
      chk("R12 wr mismatch state", line_state, 2'd2);
      chk("R12 wr mismatch bus", bus_req, 1'b0);
      snoop_wr = 1'b0;
      tick();
      snoop_valid = 1'b0;
      chk("R12 rd mismatch state", line_state, 2'd2);
      chk("R12 data kept", cpu_rdata, 32'h0000_0202);
   endtask

   task automatic t_exc_snoop_rd();
      snoop_valid = 1'b1; snoop_wr = 1'b0; snoop_addr = A;
      cpu_set(1'b0, A, '0);
      #1 chk("R11 snoop blocks cpu", cpu_ready, 1'b0);
      tick();
      snoop_valid = 1'b0; cpu_req = 1'b0;
      chk("R8 wb cmd", bus_cmd, 2'd3);
      chk("R8 wb addr", bus_addr, A);
      chk("R8 wb data", bus_wdata, 32'h0000_0202);
      grant('0);
      chk("R8 shared", line_state, 2'd1);
      chk("R8 data kept", cpu_rdata, 32'h0000_0202);
   endtask

   task automatic t_exc_snoop_wr();
      snoop_valid = 1'b1; snoop_wr = 1'b1; snoop_addr = A;
      tick();
      snoop_valid = 1'b0;
      chk("R9 wb cmd", bus_cmd, 2'd3);
      chk("R9 wb data", bus_wdata, 32'h0000_0303);
      chk("R9 busy", line_state, 2'd3);
      grant('0);
      chk("R9 invalid", line_state, 2'd0);
      chk("R9 bus idle", bus_req, 1'b0);
   endtask

   task automatic t_inv_snoop();
      snoop_valid = 1'b1; snoop_wr = 1'b1; snoop_addr = A;
      tick();
      snoop_valid = 1'b0;
      chk("R12 invalid snoop state", line_state, 2'd0);
      chk("R12 invalid snoop bus", bus_req, 1'b0);
   endtask

   task automatic t_exc_conflict_rd();
      cpu_set(1'b0, C, '0);
      tick();
      chk("R7 rd wb cmd", bus_cmd, 2'd3);
      chk("R7 rd wb addr", bus_addr, B);
      chk("R7 rd wb data", bus_wdata, 32'h0000_0404);
      grant('0);
      chk("R7 rd miss cmd", bus_cmd, 2'd1);
      chk("R7 rd miss addr", bus_addr, C);
      grant(32'hD3D3_0003);
      cpu_req = 1'b0;
      chk("R7 rd shared", line_state, 2'd1);
      chk("R7 rd fill", cpu_rdata, 32'hD3D3_0003);
   endtask

   task automatic t_shared_conflict();
      cpu_set(1'b0, D, '0);
      tick();
      chk("R13 direct rd cmd", bus_cmd, 2'd1);
      chk("R13 direct rd addr", bus_addr, D);
      grant(32'hD4D4_0004);
      cpu_req = 1'b0;
      chk("R13 shared", line_state, 2'd1);
      chk("R13 fill", cpu_rdata, 32'hD4D4_0004);
   endtask

   task automatic t_snoop_and_cpu();
      snoop_valid = 1'b1; snoop_wr = 1'b1; snoop_addr = D;
      cpu_set(1'b0, D, '0);
      #1 chk("R11 collision ready", cpu_ready, 1'b0);
      tick();
      snoop_valid = 1'b0;
      chk("R5 snoop wr invalid", line_state, 2'd0);
      chk("R5 snoop wr no bus", bus_req, 1'b0);
      tick();
      chk("R2 rd after inval cmd", bus_cmd, 2'd1);
      grant(32'hD5D5_0005);
      cpu_req = 1'b0;
      chk("R2 rd after inval fill", cpu_rdata, 32'hD5D5_0005);
   endtask

   task automatic t_exc_conflict_wr();
      cpu_set(1'b1, A, 32'h0000_0606);
      tick();
      chk("R7 wr wb cmd", bus_cmd, 2'd3);
      chk("R7 wr wb addr", bus_addr, D);
      chk("R7 wr wb data", bus_wdata, 32'h0000_0505);
      grant('0);
      chk("R7 wr miss cmd", bus_cmd, 2'd2);
      chk("R7 wr miss addr", bus_addr, A);
      grant(32'hD6D6_0006);
      chk("R7 wr exclusive", line_state, 2'd2);
      tick();
      cpu_req = 1'b0;
      chk("R7 wr data", cpu_rdata, 32'h0000_0606);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_read_from_inv();
      t_shared_hit();
      t_shared_snoop_rd();
      shared_to_exc(A, 32'hD1D1_0001, 32'h0000_0101, "R4");
      t_exc_hits();
      t_snoop_mismatch();
      t_exc_snoop_rd();
      shared_to_exc(A, 32'h0000_0202, 32'h0000_0303, "R4 again");
      t_exc_snoop_wr();
      t_inv_snoop();
      shared_to_exc(B, 32'hD2D2_0002, 32'h0000_0404, "R2 wr from invalid");
      t_exc_conflict_rd();
      t_shared_conflict();
      t_snoop_and_cpu();
      shared_to_exc(D, 32'hD5D5_0005, 32'h0000_0505, "R4 third");
      t_exc_conflict_wr();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule